// File: doc/BRIEF.md
# Second-Stage Address Translation Walker

This block turns a guest-physical address into a host-physical address by walking a four-level translation table held in memory. A client presents an address and an access kind (read, write or execute) on a valid/ready request port. The walker then issues one 64-bit entry read at a time on its memory port and waits for each reply. It ends with a single response cycle that carries either the translated address or a fault status.

Faults come in two classes, and they stay separate. A violation means an entry is absent or the access is not allowed by the permissions. A misconfiguration means an entry holds an illegal bit pattern. Entries are always checked for misconfiguration before the walk either goes down a level or checks the access, so a badly formed entry is never reported as a violation. Pages of 4 KiB (found at the last level) and 2 MiB (found at the third level) are supported.

Top module: `gpa_xlate_walker`

## Requirements
- R1: `req_ready` is 1 only while no walk is active, and a request is taken in a cycle with `req_valid` and `req_ready` both 1. While a walk is active (from the cycle after acceptance up to and including its response cycle), `req_ready` stays 0.
- R2: The first read address is `{root_base, gpa[47:39], 3'b000}`. Each later read uses bits 51:12 of the entry just read, followed by the next 9-bit index (`gpa[38:30]`, then `gpa[29:21]`, then `gpa[20:12]`) and three zero bits. `mem_req_valid` and `mem_req_addr` are held until a cycle with `mem_rsp_valid` 1.
- R3: An entry whose bits 2:0 are all 0 is absent. The walk ends with status 2'b01 (violation).
- R4: A present entry is a misconfiguration, and the walk ends with status 2'b10, in three cases: bit 1 is set while bit 0 is clear; any bit in 51:RSV_LO is set (default RSV_LO = 46); or bit 7 is set at either of the top two levels.
- R5: The misconfiguration check takes priority over the permission check. A badly formed leaf reports 2'b10 even when the access would also be denied.
- R6: Bit 7 in a third-level entry marks a 2 MiB leaf, giving `{entry[51:21], gpa[20:0]}`. Every fourth-level entry is a 4 KiB leaf, giving `{entry[51:12], gpa[11:0]}`.
- R7: The effective permission is the AND of bits 2:0 (R = bit 0, W = bit 1, X = bit 2) over all entries visited. The access codes are: 2'b00 read, 2'b01 write, 2'b10 execute, and 2'b11 handled as read. A missing permission at the leaf gives status 2'b01.
- R8: The response is a one-cycle pulse on `rsp_valid` with status 2'b00 and the translated address. On either fault, `rsp_hpa` is 0. Status 2'b11 never appears. `req_ready` returns to 1 in the next cycle.
- R9: During and right after reset, `req_ready` is 1, `mem_req_valid` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 40 | Root table base, address bits 51:12 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_gpa | input | 48 | Guest-physical address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_status | output | 2 | 00 ok, 01 violation, 10 misconfiguration |
| rsp_hpa | output | 52 | Host-physical address (0 on fault) |

## Verification
A wrong level counter or table base shows at the ports as soon as the next memory read is issued. The read goes to the wrong address, the bench memory returns a different entry, and the response status or address no longer matches what the scoreboard expects. A stale permission accumulator, or a classification done in the wrong order, shows up only in the response cycle of the affected walk. For that reason the stimulus includes leaves whose own bits allow the access but whose ancestors do not, and badly formed leaves that would also fail the permission check. A walker that fails to return to idle is seen one cycle after its response, because `req_ready` stays low.

// File: rtl/gxw_pkg.sv
// Shared types for the second-stage address translation walker.
package gxw_pkg;
    typedef enum logic [1:0] {
        WS_IDLE  = 2'b00,
        WS_FETCH = 2'b01,
        WS_DONE  = 2'b10
    } walk_state_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_VIOL = 2'b01,
        ST_MISC = 2'b10
    } walk_status_e;

    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_EXEC  = 2'b10;
    localparam int BIT_R    = 0;
    localparam int BIT_W    = 1;
    localparam int BIT_X    = 2;
    localparam int BIT_HUGE = 7;
endpackage

// File: rtl/gxw_addr_gen.sv
// Forms the byte address of the entry for the current level.
// Assumes each table is 4 KiB aligned and has 2**IDX_W eight-byte entries (IDX_W + 3 == 12).
module gxw_addr_gen #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = 9,
    parameter int PA_W    = 52,
    localparam int GPA_W  = 12 + IDX_W * NUM_LVL,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [PA_W-13:0]  tbl_base,
    input  logic [GPA_W-1:0]  gpa,
    input  logic [LVL_W-1:0]  level,
    output logic [PA_W-1:0]   ent_addr
);
    logic [IDX_W-1:0] idx_opt [NUM_LVL];
    logic             unused_gpa;

    // One index slice per level; level 0 is the last table.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_idx
        assign idx_opt[g] = gpa[12 + IDX_W*g +: IDX_W];
    end

    // Page offset bits never take part in indexing.
    assign unused_gpa = ^gpa[11:0];

    // Concatenation is exact because the index and the entry size fill 12 bits.
    assign ent_addr = {tbl_base, idx_opt[level], 3'b000};
endmodule

// File: rtl/gxw_entry_check.sv
// Classifies a fetched entry: absent, badly formed, or leaf.
// Assumes level 0 is the 4 KiB level and level 1 the 2 MiB level.
module gxw_entry_check #(
    parameter int NUM_LVL = 4,
    parameter int PA_W    = 52,
    parameter int RSV_LO  = 46,
    parameter int ENT_W   = 64,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    output logic             absent,
    output logic             malformed,
    output logic             is_leaf
);
    import gxw_pkg::*;

    logic rsv_hit;
    logic wr_no_rd;
    logic huge_high;
    logic unused_bits;

    // Reserved physical address bits must be clear.
    assign rsv_hit   = |entry[PA_W-1:RSV_LO];
    // Writable but not readable is an illegal combination.
    assign wr_no_rd  = entry[BIT_W] & ~entry[BIT_R];
    // The large-page flag is only legal at the 2 MiB level.
    assign huge_high = entry[BIT_HUGE] & (level > LVL_W'(1));

    // Classification outputs.
    assign absent    = (entry[2:0] == 3'b000);
    assign malformed = ~absent & (wr_no_rd | rsv_hit | huge_high);
    assign is_leaf   = (level == '0) | ((level == LVL_W'(1)) & entry[BIT_HUGE]);

    // Bits not checked here.
    assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[RSV_LO-1:8], entry[6:3]};
endmodule

// File: rtl/gxw_leaf_eval.sv
// Builds the output address of a leaf and checks the access against the accumulated permission.
// Assumes level 1 leaves are 2 MiB pages and level 0 leaves are 4 KiB pages.
module gxw_leaf_eval #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = 9,
    parameter int PA_W    = 52,
    parameter int ENT_W   = 64,
    localparam int GPA_W  = 12 + IDX_W * NUM_LVL,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [GPA_W-1:0] gpa,
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       perm_in,
    input  logic [1:0]       acc,
    output logic [PA_W-1:0]  hpa,
    output logic             allowed
);
    import gxw_pkg::*;

    logic [2:0] eff;
    logic       unused_bits;

    // Permission left after including the leaf itself.
    assign eff = perm_in & entry[2:0];

    // Select the permission bit the access needs.
    always_comb begin : perm_pick
        unique case (acc)
            ACC_WRITE: allowed = eff[BIT_W];
            ACC_EXEC:  allowed = eff[BIT_X];
            default:   allowed = eff[BIT_R];
        endcase
    end

    // Join frame bits with page offset according to the page size.
    always_comb begin : addr_join
        if (level == LVL_W'(1)) hpa = {entry[PA_W-1:21], gpa[20:0]};
        else                    hpa = {entry[PA_W-1:12], gpa[11:0]};
    end

    // Bits not used here.
    assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[11:3], gpa[GPA_W-1:21]};
endmodule

// File: rtl/gpa_xlate_walker.sv
// Walks a four-level second-stage table and returns a host-physical address or a fault.
// Assumes one walk at a time, memory answering each read with one mem_rsp_valid cycle,
// and the response consumer always being ready for the rsp_valid pulse.
module gpa_xlate_walker #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = 9,
    parameter int PA_W    = 52,
    parameter int RSV_LO  = 46,
    parameter int ENT_W   = 64,
    localparam int GPA_W  = 12 + IDX_W * NUM_LVL,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-13:0]  root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [GPA_W-1:0]  req_gpa,
    input  logic [1:0]        req_acc,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [PA_W-1:0]   rsp_hpa
);
    import gxw_pkg::*;

    walk_state_e       state_q;
    walk_status_e      stat_q;
    logic [GPA_W-1:0]  gpa_q;
    logic [1:0]        acc_q;
    logic [PA_W-13:0]  base_q;
    logic [LVL_W-1:0]  level_q;
    logic [2:0]        perm_q;
    logic [PA_W-1:0]   hpa_q;

    logic              ent_absent;
    logic              ent_bad;
    logic              ent_leaf;
    logic [PA_W-1:0]   leaf_hpa;
    logic              leaf_ok;

    gxw_addr_gen #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .PA_W(PA_W)) u_addr (
        .tbl_base (base_q),
        .gpa      (gpa_q),
        .level    (level_q),
        .ent_addr (mem_req_addr)
    );

    gxw_entry_check #(.NUM_LVL(NUM_LVL), .PA_W(PA_W), .RSV_LO(RSV_LO), .ENT_W(ENT_W)) u_chk_ent (
        .entry     (mem_rsp_data),
        .level     (level_q),
        .absent    (ent_absent),
        .malformed (ent_bad),
        .is_leaf   (ent_leaf)
    );

    gxw_leaf_eval #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .PA_W(PA_W), .ENT_W(ENT_W)) u_leaf (
        .entry   (mem_rsp_data),
        .gpa     (gpa_q),
        .level   (level_q),
        .perm_in (perm_q),
        .acc     (acc_q),
        .hpa     (leaf_hpa),
        .allowed (leaf_ok)
    );

    // Walk state machine: accept, fetch level by level, report.
    always_ff @(posedge clk) begin : walk_seq
        if (!rst_n) begin
            state_q <= WS_IDLE;
            stat_q  <= ST_OK;
            gpa_q   <= '0;
            acc_q   <= '0;
            base_q  <= '0;
            level_q <= '0;
            perm_q  <= '0;
            hpa_q   <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        gpa_q   <= req_gpa;
                        acc_q   <= req_acc;
                        base_q  <= root_base;
                        level_q <= LVL_W'(NUM_LVL - 1);
                        perm_q  <= 3'b111;
                        state_q <= WS_FETCH;
                    end
                end
                WS_FETCH: begin
                    if (mem_rsp_valid) begin
                        if (ent_absent) begin
                            stat_q  <= ST_VIOL;
                            hpa_q   <= '0;
                            state_q <= WS_DONE;
                        end else if (ent_bad) begin
                            stat_q  <= ST_MISC;
                            hpa_q   <= '0;
                            state_q <= WS_DONE;
                        end else if (ent_leaf) begin
                            stat_q  <= leaf_ok ? ST_OK : ST_VIOL;
                            hpa_q   <= leaf_ok ? leaf_hpa : '0;
                            state_q <= WS_DONE;
                        end else begin
                            base_q  <= mem_rsp_data[PA_W-1:12];
                            level_q <= level_q - LVL_W'(1);
                            perm_q  <= perm_q & mem_rsp_data[2:0];
                        end
                    end
                end
                WS_DONE: state_q <= WS_IDLE;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the state.
    assign req_ready     = (state_q == WS_IDLE);
    assign mem_req_valid = (state_q == WS_FETCH);
    assign rsp_valid     = (state_q == WS_DONE);
    assign rsp_status    = stat_q;
    assign rsp_hpa       = hpa_q;
endmodule

// File: rtl/gxw_checker.sv
// Port-level protocol checks for the walker, bound to every instance.
module gxw_checker #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = 9,
    parameter int PA_W    = 52,
    parameter int ENT_W   = 64,
    localparam int GPA_W  = 12 + IDX_W * NUM_LVL
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PA_W-13:0]  root_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic [GPA_W-1:0]  req_gpa,
    input logic [1:0]        req_acc,
    input logic              mem_req_valid,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [ENT_W-1:0]  mem_rsp_data,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [PA_W-1:0]   rsp_hpa
);
    logic [11:0] ofs_cap;
    logic        unused_in;

    // Capture the page offset of each accepted request.
    always_ff @(posedge clk) begin : cap_ofs
        if (!rst_n)                      ofs_cap <= '0;
        else if (req_valid && req_ready) ofs_cap <= req_gpa[11:0];
    end

    assign unused_in = ^{req_acc, mem_rsp_data};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid &&
            mem_req_addr == {$past(root_base), $past(req_gpa[GPA_W-1 -: IDX_W]), 3'b000}));

    p_hold_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b00) |-> (rsp_hpa[11:0] == ofs_cap));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b00) |-> (rsp_hpa == '0));

    p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11));
endmodule

bind gpa_xlate_walker gxw_checker #(
    .NUM_LVL (NUM_LVL),
    .IDX_W   (IDX_W),
    .PA_W    (PA_W),
    .ENT_W   (ENT_W)
) u_gxw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_base     (root_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_gpa       (req_gpa),
    .req_acc       (req_acc),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_hpa       (rsp_hpa)
);

// File: tb/tb_gpa_xlate_walker.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, and the monitor compares them with each response.
module tb_gpa_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] root_base = 40'h1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_gpa = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [51:0] rsp_hpa;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [63:0] mem [logic [51:0]];
    logic [1:0]  exp_st  [$];
    logic [51:0] exp_hpa [$];
    string       exp_tag [$];

    int lat = 0;
    int cnt = 0;
    bit busy = 1'b0;

    always #2.5 clk = ~clk;

    gpa_xlate_walker dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_gpa(req_gpa), .req_acc(req_acc),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_hpa(rsp_hpa)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: serve each read after lat idle cycles.
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
            busy <= 1'b0;
        end else if (mem_req_valid && !busy) begin
            busy <= 1'b1;
            cnt  <= lat;
        end else if (busy) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    // Monitor: compare each response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_st.size() == 0) begin
                chk(1'b0, "R8 unexpected response", {62'h0, rsp_status}, 64'h0);
            end else begin
                logic [1:0]  es;
                logic [51:0] eh;
                string       et;
                es = exp_st.pop_front();
                eh = exp_hpa.pop_front();
                et = exp_tag.pop_front();
                chk(rsp_status == es, {et, " status"}, {62'h0, rsp_status}, {62'h0, es});
                chk(rsp_hpa == eh, {et, " hpa"}, {12'h0, rsp_hpa}, {12'h0, eh});
            end
        end
    end

    task automatic do_req(input logic [47:0] gpa, input logic [1:0] acc,
                          input logic [1:0] st, input logic [51:0] hpa, input string tag);
        exp_st.push_back(st);
        exp_hpa.push_back(hpa);
        exp_tag.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_gpa   = gpa;
        req_acc   = acc;
        @(negedge clk);
        req_valid = 1'b0;
        // R1: the walker is busy; R2: the first read uses the root and the top index.
        chk(req_ready == 1'b0, {tag, " R1 ready low in walk"}, {63'h0, req_ready}, 64'h0);
        chk(mem_req_valid && mem_req_addr == {root_base, gpa[47:39], 3'b000},
            {tag, " R2 first read address"}, {12'h0, mem_req_addr},
            {12'h0, root_base, gpa[47:39], 3'b000});
        while (exp_st.size() != 0) @(negedge clk);
        @(negedge clk);
        // R8: back to idle one cycle after the response.
        chk(req_ready && !rsp_valid, {tag, " R8 idle after response"},
            {62'h0, req_ready, rsp_valid}, 64'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Tables: top at 0x1000, second level at 0x2000, third at 0x3000/0x6000, last at 0x4000/0x5000.
        mem[52'h1000] = 64'h2007;
        mem[52'h2000] = 64'h3007;
        mem[52'h2008] = 64'h9087;
        mem[52'h2010] = 64'h6005;
        mem[52'h3000] = 64'h4007;
        mem[52'h3008] = 64'h4060_0081;
        mem[52'h3010] = 64'h2;
        mem[52'h3018] = 64'h5007;
        mem[52'h4028] = 64'hABCD_E003;
        mem[52'h5008] = (64'h1 << 51) | 64'h7001;
        mem[52'h5010] = 64'h8004;
        mem[52'h5018] = (64'h1 << 46) | 64'h9007;
        mem[52'h5020] = (64'h1 << 45) | 64'hA007;
        mem[52'h6000] = 64'h20_0087;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R9 reset outputs",
            {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R9 after reset",
            {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);

        lat = 0; do_req(48'h5123, 2'b00, 2'b00, 52'hABCD_E123, "R6 4K read");
        lat = 2; do_req(48'h5123, 2'b01, 2'b00, 52'hABCD_E123, "R7 4K write");
        lat = 1; do_req(48'h5123, 2'b10, 2'b01, 52'h0, "R7 exec denied");
        lat = 0; do_req(48'h21_2345, 2'b00, 2'b00, 52'h4061_2345, "R6 2M read");
        lat = 3; do_req(48'h21_2345, 2'b01, 2'b01, 52'h0, "R7 2M write denied");
        lat = 0; do_req(48'h21_2345, 2'b11, 2'b00, 52'h4061_2345, "R7 code 11 as read");
        lat = 1; do_req(48'h40_0000, 2'b00, 2'b10, 52'h0, "R4 write without read");
        lat = 0; do_req(48'h60_0000, 2'b00, 2'b01, 52'h0, "R3 absent last level");
        lat = 2; do_req(48'h60_1000, 2'b01, 2'b10, 52'h0, "R5 reserved over permission");
        lat = 0; do_req(48'h60_2000, 2'b10, 2'b00, 52'h8000, "R7 exec-only exec");
        lat = 1; do_req(48'h60_2ABC, 2'b00, 2'b01, 52'h0, "R7 exec-only read");
        lat = 0; do_req(48'h60_3000, 2'b00, 2'b10, 52'h0, "R4 lowest reserved bit");
        lat = 0; do_req(48'h60_4010, 2'b00, 2'b00, 52'h2000_0000_A010, "R4 bit below reserved");
        lat = 1; do_req(48'h4000_0000, 2'b00, 2'b10, 52'h0, "R4 large flag high level");
        lat = 0; do_req(48'h80_0000_0000, 2'b00, 2'b01, 52'h0, "R3 absent top level");
        lat = 2; do_req(48'h8000_1ABC, 2'b01, 2'b01, 52'h0, "R7 ancestor lacks write");
        lat = 0; do_req(48'h8000_1ABC, 2'b00, 2'b00, 52'h20_1ABC, "R6 2M via second branch");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule